// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block turns an asynchronous serial input line into characters. A 16x oversampling enable paces it. Each bit is resolved by a programmable majority vote around the middle of the bit, which rejects short noise spikes. Every character carries three error flags: parity error, frame error and break. The character and its flags go together into a small receive queue. The reader sees the oldest character and its flags at the queue head, and removes it with a read strobe.

The line format settings (word length, parity enable and sense) come from a configuration shared with the transmitter. They must be held steady while a character is being received. A sticky overrun flag records characters lost to a full queue, and is cleared by a status-read strobe. An active-low request-to-send output is driven either from a software bit or, in automatic mode, from the free space in the queue with hysteresis.

The receive sequencer has six states:
- ST_IDLE hunts for a low line. It moves to ST_START (start seen) on a tick with the line low.
- ST_START leaves on "start rejected" back to ST_IDLE when the voted mid-start value is 1. Otherwise it takes "start confirmed" to ST_DATA at the end of the bit.
- ST_DATA takes "data done" to ST_PARITY or, with parity off, to ST_STOP after the last data bit.
- ST_PARITY takes "parity done" to ST_STOP.
- ST_STOP takes "character stored" back to ST_IDLE at the stop-bit vote. When every sampled bit was 0 it takes "break seen" to ST_BRKWAIT instead.
- ST_BRKWAIT takes "line released" to ST_IDLE on a tick with the line high.

Top module: `serial_rx_voter`

## Requirements
- R1: After reset the receive queue is empty (rx_ready=0) and ovr_flag=0. With auto_rts=1, rts_n is 0 because the queue is fully free.
- R2: cfg_vote selects the bit decision: 0 takes the single sample at tick 8 of the 16 ticks of a bit, and 1, 2 and 3 take the majority of 3, 5 and 7 samples centred on tick 8 (ticks 8-v to 8+v).
- R3: A character is a low start bit, then 5, 6, 7 or 8 data bits (cfg_wlen 0..3) least significant first, an optional parity bit, and a stop bit. rd_data holds the bits right-justified with the unused upper bits 0.
- R4: A start is confirmed only if the voted value at mid-start is 0. Otherwise the receiver returns to hunting and stores nothing.
- R5: With cfg_par_en=1, the bit after the data is parity: cfg_par_even=0 means odd, 1 means even. A mismatch sets rd_perr for that character.
- R6: A voted stop bit of 0 sets rd_ferr for that character.
- R7: When the data bits, the parity bit (if enabled) and the stop bit all vote 0, the character is stored as 0x00 with rd_brk=1, rd_ferr=1 and rd_perr=0. No further character is taken until the line has returned high.
- R8: rx_ready is 1 exactly when the queue holds a character. rd_data and its flags show the oldest character, and rd_en removes it. Characters leave in arrival order.
- R9: A character completed while the queue holds DEPTH entries is dropped and sets ovr_flag. A stat_rd pulse clears ovr_flag; a new loss in the same cycle keeps it set.
- R10: With auto_rts=1, rts_n goes high when the free queue space is below 2 entries. It returns low once the free space is 4 or more, and holds its value in between.
- R11: With auto_rts=0, rts_n is the inverse of sw_rts (sw_rts=1 drives rts_n low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| cfg_vote | input | 2 | Vote width select: 0 single, 1/2/3 for 3/5/7 samples |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| rd_en | input | 1 | Remove head character |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head character parity error |
| rd_ferr | output | 1 | Head character frame error |
| rd_brk | output | 1 | Head character is a break |
| rx_ready | output | 1 | Queue not empty |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| ovr_flag | output | 1 | Sticky overrun |
| auto_rts | input | 1 | Request-to-send follows queue space |
| sw_rts | input | 1 | Software request-to-send, 1 = active |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
On every cycle, the assertions check:
- the overrun flag setting and clearing;
- queue occupancy staying within depth;
- rx_ready falling only after a read;
- both hysteresis thresholds of automatic request-to-send;
- a rejected start returning the sequencer to hunting;
- every stored break carrying a zero byte and a frame error.

The character values themselves, vote majority under injected spikes, false-start filtering, parity sense per word length and the break line-release wait depend on whole serial waveforms. Only the bench's sweeps, compared against arithmetically computed expectations, show these.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_t;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [CHAR_W-1:0] data;
    } rx_char_t;
endpackage

// File: rtl/rxv_vote.sv
module rxv_vote #(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          active,
    input  logic [CW-1:0] phase,
    input  logic [1:0]    span,
    input  logic          din,
    output logic          decide,
    output logic          bit_val
);
    localparam int MID = OSR / 2;

    logic [2:0] ones_q;
    logic [2:0] total;
    logic       in_win;
    int         win_lo;
    int         win_hi;

    always_comb begin
        win_lo  = MID - int'(span);
        win_hi  = MID + int'(span);
        in_win  = active && tick && (int'(phase) >= win_lo) && (int'(phase) <= win_hi);
        decide  = active && tick && (int'(phase) == win_hi);
        total   = ones_q + {2'b00, din};
        bit_val = total > {1'b0, span};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ones_q <= '0;
        else if (decide)
            ones_q <= '0;
        else if (in_win)
            ones_q <= total;
    end
endmodule

// File: rtl/rxv_frame.sv
module rxv_frame
    import rxv_pkg::*;
#(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd_s,
    input  logic [1:0]    cfg_wlen,
    input  logic          cfg_par_en,
    input  logic          cfg_par_even,
    input  logic          decide,
    input  logic          bit_val,
    output logic [CW-1:0] phase,
    output logic          active,
    output rx_state_t     state,
    output logic          push,
    output rx_char_t      push_char
);
    rx_state_t         st_q, st_d;
    logic [CW-1:0]     phase_q;
    logic [3:0]        bit_idx_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              zero_q;
    logic              par_q;
    logic              push_q;
    rx_char_t          char_q;

    logic [3:0]        nbits;
    logic              bit_end;
    logic [CHAR_W-1:0] data_just;
    logic              brk_c;
    logic              pe_c;

    always_comb begin
        nbits     = {2'b00, cfg_wlen} + 4'd5;
        bit_end   = tick && (phase_q == CW'(OSR - 1));
        data_just = shreg_q >> (4'd8 - nbits);
        brk_c     = zero_q & ~bit_val;
        pe_c      = ~brk_c & cfg_par_en & (^data_just ^ par_q ^ ~cfg_par_even);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (tick && !rxd_s) st_d = ST_START;
            ST_START: begin
                if (decide && bit_val)   st_d = ST_IDLE;
                else if (bit_end)        st_d = ST_DATA;
            end
            ST_DATA:    if (bit_end && bit_idx_q == nbits)
                            st_d = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:  if (bit_end) st_d = ST_STOP;
            ST_STOP:    if (decide) st_d = brk_c ? ST_BRKWAIT : ST_IDLE;
            ST_BRKWAIT: if (tick && rxd_s) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= '0;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            zero_q    <= 1'b1;
            par_q     <= 1'b0;
            push_q    <= 1'b0;
            char_q    <= '0;
        end else begin
            push_q <= 1'b0;
            if (tick) begin
                if (st_q == ST_IDLE || st_q == ST_BRKWAIT)
                    phase_q <= CW'(1);
                else if (phase_q == CW'(OSR - 1))
                    phase_q <= '0;
                else
                    phase_q <= phase_q + 1'b1;
            end
            if (st_q == ST_IDLE) begin
                bit_idx_q <= '0;
                shreg_q   <= '0;
                zero_q    <= 1'b1;
            end
            if (decide) begin
                unique case (st_q)
                    ST_DATA: begin
                        shreg_q   <= {bit_val, shreg_q[CHAR_W-1:1]};
                        zero_q    <= zero_q & ~bit_val;
                        bit_idx_q <= bit_idx_q + 4'd1;
                    end
                    ST_PARITY: begin
                        par_q  <= bit_val;
                        zero_q <= zero_q & ~bit_val;
                    end
                    ST_STOP: begin
                        push_q      <= 1'b1;
                        char_q.data <= data_just;
                        char_q.brk  <= brk_c;
                        char_q.fe   <= ~bit_val;
                        char_q.pe   <= pe_c;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign phase     = phase_q;
    assign active    = (st_q == ST_START) || (st_q == ST_DATA) ||
                       (st_q == ST_PARITY) || (st_q == ST_STOP);
    assign state     = st_q;
    assign push      = push_q;
    assign push_char = char_q;
endmodule

// File: rtl/rxv_fifo.sv
module rxv_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [W-1:0]    wdata,
    input  logic            pop,
    output logic [W-1:0]    head,
    output logic [CNTW-1:0] count,
    output logic            ovf
);
    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wptr_q, rptr_q;
    logic [CNTW-1:0] cnt_q;
    logic            full, empty, do_push, do_pop;

    always_comb begin
        full    = (cnt_q == CNTW'(DEPTH));
        empty   = (cnt_q == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        ovf     = push && full;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_pop)
                rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rptr_q];
    assign count = cnt_q;
endmodule

// File: rtl/rxv_flow.sv
module rxv_flow #(
    parameter int DEPTH         = 8,
    parameter int RTS_OFF_BELOW = 2,
    parameter int RTS_ON_AT     = 4,
    parameter int CNTW          = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] count,
    input  logic            auto_rts,
    input  logic            sw_rts,
    output logic            rts_n
);
    logic [CNTW-1:0] free_sp;
    logic            room_q;

    assign free_sp = CNTW'(DEPTH) - count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            room_q <= 1'b1;
        else if (free_sp < CNTW'(RTS_OFF_BELOW))
            room_q <= 1'b0;
        else if (free_sp >= CNTW'(RTS_ON_AT))
            room_q <= 1'b1;
    end

    assign rts_n = auto_rts ? ~room_q : ~sw_rts;
endmodule

// File: rtl/serial_rx_voter.sv
module serial_rx_voter
    import rxv_pkg::*;
#(
    parameter int OSR           = 16,
    parameter int DEPTH         = 8,
    parameter int RTS_OFF_BELOW = 2,
    parameter int RTS_ON_AT     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_16x,
    input  logic       rxd,
    input  logic [1:0] cfg_vote,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       rx_ready,
    input  logic       stat_rd,
    output logic       ovr_flag,
    input  logic       auto_rts,
    input  logic       sw_rts,
    output logic       rts_n
);
    localparam int CW   = $clog2(OSR);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int CHW  = $bits(rx_char_t);

    logic [1:0]      sync_q;
    logic            rxd_s;
    logic [CW-1:0]   phase_w;
    logic            active_w;
    logic            vote_decide;
    logic            vote_bit;
    rx_state_t       st_w;
    logic            push_w;
    rx_char_t        push_char_w;
    rx_char_t        head_w;
    logic [CNTW-1:0] fifo_cnt;
    logic            fifo_ovf;
    logic            ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end
    assign rxd_s = sync_q[1];

    rxv_vote #(.OSR(OSR)) u_vote (
        .clk(clk), .rst_n(rst_n), .tick(tick_16x), .active(active_w),
        .phase(phase_w), .span(cfg_vote), .din(rxd_s),
        .decide(vote_decide), .bit_val(vote_bit)
    );

    rxv_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick_16x), .rxd_s(rxd_s),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .decide(vote_decide), .bit_val(vote_bit),
        .phase(phase_w), .active(active_w), .state(st_w),
        .push(push_w), .push_char(push_char_w)
    );

    rxv_fifo #(.W(CHW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_w), .wdata(push_char_w),
        .pop(rd_en), .head(head_w), .count(fifo_cnt), .ovf(fifo_ovf)
    );

    rxv_flow #(.DEPTH(DEPTH), .RTS_OFF_BELOW(RTS_OFF_BELOW), .RTS_ON_AT(RTS_ON_AT)) u_flow (
        .clk(clk), .rst_n(rst_n), .count(fifo_cnt), .auto_rts(auto_rts),
        .sw_rts(sw_rts), .rts_n(rts_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovr_q <= 1'b0;
        else if (fifo_ovf) ovr_q <= 1'b1;
        else if (stat_rd)  ovr_q <= 1'b0;
    end

    assign rd_data  = head_w.data;
    assign rd_perr  = head_w.pe;
    assign rd_ferr  = head_w.fe;
    assign rd_brk   = head_w.brk;
    assign rx_ready = (fifo_cnt != '0);
    assign ovr_flag = ovr_q;
endmodule

// File: rtl/rxv_checks.sv
module rxv_checks
    import rxv_pkg::*;
#(
    parameter int DEPTH         = 8,
    parameter int RTS_OFF_BELOW = 2,
    parameter int RTS_ON_AT     = 4,
    parameter int CNTW          = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stat_rd,
    input logic            fifo_ovf,
    input logic            ovr_flag,
    input logic            rx_ready,
    input logic            rd_en,
    input logic [CNTW-1:0] fifo_cnt,
    input logic            auto_rts,
    input logic            rts_n,
    input logic            push,
    input rx_char_t        push_char,
    input rx_state_t       state,
    input logic            decide,
    input logic            bit_val
);
    int free_sp;
    assign free_sp = DEPTH - int'(fifo_cnt);

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !fifo_ovf |=> !ovr_flag);

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf |=> ovr_flag);

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ready) |-> $past(rd_en));

    // R8
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_sp >= 0);

    // R10
    rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_rts && free_sp < RTS_OFF_BELOW |=> !auto_rts || rts_n);

    // R10
    rts_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_rts && free_sp >= RTS_ON_AT |=> !auto_rts || !rts_n);

    // R4
    start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START && decide && bit_val |=> state == ST_IDLE);

    // R7
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && push_char.brk |-> push_char.data == '0 && push_char.fe && !push_char.pe);
endmodule

bind serial_rx_voter rxv_checks #(
    .DEPTH(DEPTH), .RTS_OFF_BELOW(RTS_OFF_BELOW), .RTS_ON_AT(RTS_ON_AT)
) u_checks (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .fifo_ovf(fifo_ovf),
    .ovr_flag(ovr_flag), .rx_ready(rx_ready), .rd_en(rd_en), .fifo_cnt(fifo_cnt),
    .auto_rts(auto_rts), .rts_n(rts_n), .push(push_w), .push_char(push_char_w),
    .state(st_w), .decide(vote_decide), .bit_val(vote_bit)
);

// File: tb/serial_rx_voter_test.sv
module serial_rx_voter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_vote = 2'd0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, rx_ready;
    logic       stat_rd = 1'b0;
    logic       ovr_flag;
    logic       auto_rts = 1'b1;
    logic       sw_rts = 1'b0;
    logic       rts_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    serial_rx_voter uut (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
        .cfg_vote(cfg_vote), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .rd_en(rd_en), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk), .rx_ready(rx_ready),
        .stat_rd(stat_rd), .ovr_flag(ovr_flag), .auto_rts(auto_rts),
        .sw_rts(sw_rts), .rts_n(rts_n)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // bit index 0 = start, 1..nb = data, then parity, then stop
    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit peven, input bit pflip, input bit stopv,
                              input int gbit, input logic [15:0] gmask);
        logic [7:0] dm;
        bit p;
        bit bits[12];
        int n;
        dm = d & 8'((9'd1 << nb) - 9'd1);
        p = (peven ? ^dm : ~^dm) ^ pflip;
        n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < nb; i++) begin bits[n] = dm[i]; n++; end
        if (pen) begin bits[n] = p; n++; end
        bits[n] = stopv; n++;
        for (int b = 0; b < n; b++)
            for (int t = 0; t < 16; t++) begin
                rxd = bits[b] ^ ((b == gbit) ? gmask[t] : 1'b0);
                @(negedge clk);
            end
    endtask

    task automatic expect_char(input string req, input int d, input int pe,
                               input int fe, input int brk);
        chk({req, " ready"}, rx_ready, 1);
        chk({req, " data"}, rd_data, d);
        chk({req, " perr"}, rd_perr, pe);
        chk({req, " ferr"}, rd_ferr, fe);
        chk({req, " brk"}, rd_brk, brk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit room;
        int free_sp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 ovr_flag", ovr_flag, 0);
        chk("R1 rts_n", rts_n, 0);
        auto_rts = 1'b0;

        // R3 every byte, 8 bits, no parity, single sample
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 8, 0, 0, 0, 1, -1, 16'h0);
            hold(1'b1, 40);
            expect_char("R3 byte", v, 0, 0, 0);
        end

        // R2 R3 R5 vote x length x parity
        for (int h = 0; h < 4; h++)
            for (int w = 0; w < 4; w++)
                for (int pm = 0; pm < 3; pm++)
                    for (int ds = 0; ds < 2; ds++) begin
                        logic [7:0] d;
                        int nb;
                        bit flip;
                        d = ds ? 8'h3C : 8'hA5;
                        nb = w + 5;
                        flip = (pm != 0) && (ds == 1);
                        cfg_vote = 2'(h); cfg_wlen = 2'(w);
                        cfg_par_en = (pm != 0); cfg_par_even = (pm == 2);
                        send_frame(d, nb, pm != 0, pm == 2, flip, 1, -1, 16'h0);
                        hold(1'b1, 40);
                        expect_char("R5 R3 sweep", int'(d & 8'((9'd1 << nb) - 9'd1)),
                                    int'(flip), 0, 0);
                    end
        cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b0;

        // R2 spike majority: k high samples from the window start on data bit 0
        for (int h = 0; h < 4; h++)
            for (int k = 0; k < 8; k++) begin
                logic [15:0] m;
                int got;
                m = '0;
                for (int t = 0; t < 16; t++)
                    if (t >= 8 - h && t < 8 - h + k) m[t] = 1'b1;
                got = ((k < 2 * h + 1 ? k : 2 * h + 1) >= h + 1) ? 1 : 0;
                cfg_vote = 2'(h);
                send_frame(8'h00, 8, 0, 0, 0, 1, 1, m);
                hold(1'b1, 40);
                expect_char("R2 vote", got, 0, 0, 0);
            end

        // R4 false start: line low for L ticks then high
        for (int h = 0; h < 4; h++)
            for (int li = 0; li < 5; li++) begin
                int L, lc;
                L = (li == 0) ? 2 : (li == 1) ? 7 : (li == 2) ? 8 : (li == 3) ? 9 : 11;
                lc = L - (8 - h);
                if (lc < 0) lc = 0;
                if (lc > 2 * h + 1) lc = 2 * h + 1;
                cfg_vote = 2'(h);
                hold(1'b0, L);
                hold(1'b1, 16 * 12);
                if (lc >= h + 1)
                    expect_char("R4 accepted start", 255, 0, 0, 0);
                else
                    chk("R4 rejected start", rx_ready, 0);
            end

        // R6 frame error
        cfg_vote = 2'd1;
        send_frame(8'h55, 8, 0, 0, 0, 0, -1, 16'h0);
        hold(1'b1, 40);
        expect_char("R6 stop low", 8'h55, 0, 1, 0);
        chk("R6 single char", rx_ready, 0);

        // R7 break with odd parity enabled, line held low long
        cfg_vote = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
        send_frame(8'h00, 8, 1, 0, 1, 0, -1, 16'h0);
        hold(1'b0, 80);
        hold(1'b1, 40);
        expect_char("R7 break", 0, 0, 1, 1);
        chk("R7 waits for high", rx_ready, 0);
        cfg_par_en = 1'b0;

        // R8 R9 R10 fill past depth with automatic request-to-send
        auto_rts = 1'b1;
        room = 1;
        @(negedge clk);
        for (int k = 1; k <= 8; k++) begin
            send_frame(8'(8'h10 + k), 8, 0, 0, 0, 1, -1, 16'h0);
            hold(1'b1, 40);
            free_sp = 8 - k;
            if (free_sp < 2) room = 0; else if (free_sp >= 4) room = 1;
            chk("R10 fill rts_n", rts_n, int'(!room));
            chk("R8 fill ready", rx_ready, 1);
            chk("R9 no loss yet", ovr_flag, 0);
        end
        send_frame(8'h99, 8, 0, 0, 0, 1, -1, 16'h0);
        hold(1'b1, 40);
        chk("R9 overrun set", ovr_flag, 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
        chk("R9 overrun cleared", ovr_flag, 0);
        for (int k = 1; k <= 8; k++) begin
            expect_char("R8 order", 8'h10 + k, 0, 0, 0);
            free_sp = k;
            if (free_sp < 2) room = 0; else if (free_sp >= 4) room = 1;
            chk("R10 drain rts_n", rts_n, int'(!room));
        end
        chk("R9 dropped char", rx_ready, 0);

        // R11 manual request-to-send
        auto_rts = 1'b0; sw_rts = 1'b1;
        @(negedge clk);
        chk("R11 sw active", rts_n, 0);
        sw_rts = 1'b0;
        @(negedge clk);
        chk("R11 sw inactive", rts_n, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule